// File: doc/BRIEF.md
# NAND Flash Bus Sequencer

This block drives an 8-bit asynchronous NAND flash bus from a synchronous system clock. A controller gives it one request at a time over a valid/ready port. The request kinds are a command byte, an address byte, a data byte to write, a burst of data bytes to read, and a wait for the device's ready/busy line. The block produces the chip-enable, command-latch, address-latch, write and read strobes. It owns the output-enable of the shared I/O bus and returns each byte it reads on a separate valid-qualified output.

All strobe timing comes from clock-cycle counts given as parameters. Each minimum (strobe low, strobe high, full cycle) is met by rounding up, never down. The write-protect pin stays asserted from reset until the `wp_enable` input asks for writes. Whenever it changes, no write strobe may start until a settling count has elapsed. A column counter follows the position inside one page. Data cycles past the last byte of the page are suppressed. A busy wait that runs past its limit sets a sticky error and frees the request port.

Top module: `nfc_seq`

## Requirements
- R1: After reset, nand_ce_n, nand_we_n and nand_re_n are 1; nand_cle, nand_ale, nand_io_oe, nand_wp_n, err_timeout and rd_valid are 0; req_ready is 1.
- R2: A request with req_kind = 0 (command) produces exactly one nand_we_n low pulse. At its rising edge nand_cle = 1, nand_ale = 0, nand_io_oe = 1 and nand_io_out equals req_data. A command also resets the column counter to 0.
- R3: A request with req_kind = 1 (address) produces exactly one nand_we_n low pulse. At its rising edge nand_ale = 1, nand_cle = 0 and nand_io_out equals req_data. nand_cle and nand_ale are never 1 together.
- R4: A request with req_kind = 2 (write data) produces one nand_we_n low pulse with nand_cle = nand_ale = 0 and nand_io_out equal to req_data, and advances the column counter by one.
- R5: Every nand_we_n or nand_re_n low pulse lasts exactly T_LOW clock cycles. The strobe then stays high at least T_HIGH cycles, and low plus following high time is at least T_CYCLE cycles.
- R6: A request with req_kind = 3 (read) and req_len = N issues N nand_re_n pulses, each advancing the column counter. For each pulse it returns on rd_data, with a one-cycle rd_valid, the value of nand_io_in at the clock edge where nand_re_n rises. nand_io_oe is 0 whenever nand_re_n is 0.
- R7: The column counter never passes PAGE_BYTES (default 2112). A write request at column PAGE_BYTES is accepted without a strobe. A read burst stops at the end of the page, so it returns no more than PAGE_BYTES minus the start column bytes.
- R8: A request with req_kind = 4 (busy wait) holds req_ready low until nand_rb_n is seen high. During the first RB_MASK cycles of the wait, a high nand_rb_n is ignored.
- R9: If nand_rb_n stays low for BUSY_TIMEOUT cycles of a wait, err_timeout becomes 1 and the request port returns to ready. err_timeout then stays 1 until reset.
- R10: nand_wp_n is 0 from reset until wp_enable is 1 and follows wp_enable one cycle later. No nand_we_n falling edge occurs within WP_SETTLE cycles of a change of nand_wp_n.
- R11: nand_ce_n is 0 whenever nand_we_n or nand_re_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken on a cycle with req_valid high |
| req_kind | input | 3 | 0 command, 1 address, 2 write data, 3 read burst, 4 busy wait |
| req_data | input | 8 | Byte for command, address or write requests |
| req_len | input | LEN_W | Byte count for read bursts |
| rd_valid | output | 1 | One-cycle pulse marking a returned byte |
| rd_data | output | 8 | Byte captured from the bus |
| wp_enable | input | 1 | 1 releases write protection |
| err_timeout | output | 1 | Sticky busy-wait timeout flag |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_rb_n | input | 1 | Ready/busy from the device, low while busy |
| nand_io_in | input | 8 | Bus value from the pad |
| nand_io_out | output | 8 | Bus value driven to the pad |
| nand_io_oe | output | 1 | Pad output enable |

## Verification
The write path is driven with a command followed by three address bytes and two data bytes. The logged latch flags on each write strobe separate command, address and data cycles, and the logged bytes show that payloads are neither swapped nor dropped. Short read bursts and a burst longer than one page are compared against a bus model whose byte value changes after each read strobe. This shows whether the capture uses the value present at the strobe's rising edge, and whether the column limit cuts the burst at the exact byte. Busy waits are run three ways: with the line already high (tests the mask window), released late (normal completion), and never released (the timeout and its stickiness). A write strobe issued right after write protection is released shows whether the settling gap is enforced.

// File: rtl/nfc_pkg.sv
// Shared definitions for the NAND bus sequencer.
// Assumes: request kinds are encoded on three bits as listed below.
package nfc_pkg;
    localparam logic [2:0] KIND_CMD  = 3'd0;
    localparam logic [2:0] KIND_ADDR = 3'd1;
    localparam logic [2:0] KIND_WR   = 3'd2;
    localparam logic [2:0] KIND_RD   = 3'd3;
    localparam logic [2:0] KIND_WAIT = 3'd4;

    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} strobe_ph_e;
    typedef enum logic [1:0] {S_IDLE, S_XFER, S_WAIT} seq_st_e;
endpackage

// File: rtl/nfc_strobe.sv
// One strobe generator shared by the write and read strobes.
// A level request 'go' taken while idle gives a low phase of LOW_CYC
// cycles, then a high phase of HIGH_CYC cycles. 'sample' marks the last
// low cycle: the strobe rises on the edge that ends it. 'done' marks the
// last high cycle.
// Assumes: LOW_CYC >= 1 and HIGH_CYC >= 1.
module nfc_strobe
    import nfc_pkg::*;
#(
    parameter int LOW_CYC  = 4,
    parameter int HIGH_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic strobe_n,
    output logic busy,
    output logic sample,
    output logic done
);
    localparam int MAXC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    strobe_ph_e    ph;
    logic [CW-1:0] cnt;

    // Phase sequencer: idle -> low -> high -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= PH_IDLE;
            cnt      <= '0;
            strobe_n <= 1'b1;
        end else begin
            unique case (ph)
                PH_IDLE: if (go) begin
                    ph       <= PH_LOW;
                    cnt      <= CW'(LOW_CYC - 1);
                    strobe_n <= 1'b0;
                end
                PH_LOW: if (cnt == '0) begin
                    ph       <= PH_HIGH;
                    cnt      <= CW'(HIGH_CYC - 1);
                    strobe_n <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                PH_HIGH: if (cnt == '0) ph <= PH_IDLE;
                         else cnt <= cnt - 1'b1;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign busy   = (ph != PH_IDLE);
    assign sample = (ph == PH_LOW)  && (cnt == '0);
    assign done   = (ph == PH_HIGH) && (cnt == '0);

    // R5
    strobe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_n) |-> $past(go));
endmodule

// File: rtl/nfc_busy_wait.sv
// Ready/busy watcher. Synchronises the device's ready/busy line. After
// 'start' it reports 'ok' once the line reads high after the mask window.
// If the line stays low for TIMEOUT cycles it reports 'expired' instead.
// Assumes: MASK < TIMEOUT.
module nfc_busy_wait #(
    parameter int TIMEOUT = 400000,
    parameter int MASK    = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rb_n,
    output logic ok,
    output logic expired
);
    localparam int TW = $clog2(TIMEOUT + 1);

    logic          rb_meta, rb_s, active;
    logic [TW-1:0] cnt;

    // Two-flop synchroniser for the asynchronous ready/busy line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_meta <= 1'b1;
            rb_s    <= 1'b1;
        end else begin
            rb_meta <= rb_n;
            rb_s    <= rb_meta;
        end
    end

    assign ok      = active && rb_s && (cnt >= TW'(MASK));
    assign expired = active && !ok && (cnt == TW'(TIMEOUT - 1));

    // Wait window counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            if (ok || expired) active <= 1'b0;
            else               cnt    <= cnt + 1'b1;
        end
    end

    // R9
    expire_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !start) |=> !active);
endmodule

// File: rtl/nfc_seq.sv
// NAND bus sequencer top. Takes one request at a time and runs the bus
// cycles for it: command, address, write data, read burst or busy wait.
// It also drives write protect with a settling guard.
// Assumes: the pad combines nand_io_out/nand_io_oe into the bidirectional
// bus and returns the pin value on nand_io_in.
module nfc_seq
    import nfc_pkg::*;
#(
    parameter int T_LOW        = 4,
    parameter int T_HIGH       = 2,
    parameter int T_CYCLE      = 7,
    parameter int WP_SETTLE    = 13,
    parameter int BUSY_TIMEOUT = 400000,
    parameter int RB_MASK      = 13,
    parameter int PAGE_BYTES   = 2112,
    parameter int LEN_W        = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_kind,
    input  logic [7:0]       req_data,
    input  logic [LEN_W-1:0] req_len,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    input  logic             wp_enable,
    output logic             err_timeout,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic             nand_wp_n,
    input  logic             nand_rb_n,
    input  logic [7:0]       nand_io_in,
    output logic [7:0]       nand_io_out,
    output logic             nand_io_oe
);
    localparam int HI_CNT = (T_HIGH > T_CYCLE - T_LOW) ? T_HIGH : (T_CYCLE - T_LOW);
    localparam int COL_W  = $clog2(PAGE_BYTES + 1);
    localparam int GW     = $clog2(WP_SETTLE + 1);
    localparam logic [COL_W-1:0] COL_END = COL_W'(PAGE_BYTES);

    seq_st_e          st;
    logic             pend, rd_mode, go, accept;
    logic             stb_n, stb_busy, smp, dn;
    logic             bw_start, bw_ok, bw_exp;
    logic [COL_W-1:0] col;
    logic [LEN_W-1:0] remain;
    logic [GW-1:0]    guard;

    assign req_ready = (st == S_IDLE) && (guard == '0);
    assign accept    = req_valid && req_ready;
    assign go        = pend && !stb_busy &&
                       (rd_mode || ((guard == '0) && (nand_wp_n == wp_enable)));

    nfc_strobe #(.LOW_CYC(T_LOW), .HIGH_CYC(HI_CNT)) u_strobe (
        .clk(clk), .rst_n(rst_n), .go(go), .strobe_n(stb_n),
        .busy(stb_busy), .sample(smp), .done(dn)
    );

    nfc_busy_wait #(.TIMEOUT(BUSY_TIMEOUT), .MASK(RB_MASK)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(bw_start), .rb_n(nand_rb_n),
        .ok(bw_ok), .expired(bw_exp)
    );

    assign nand_we_n = rd_mode ? 1'b1 : stb_n;
    assign nand_re_n = rd_mode ? stb_n : 1'b1;
    assign nand_ce_n = (st == S_IDLE);

    // Write-protect follower with settling guard after every change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nand_wp_n <= 1'b0;
            guard     <= '0;
        end else begin
            nand_wp_n <= wp_enable;
            if (nand_wp_n != wp_enable) guard <= GW'(WP_SETTLE);
            else if (guard != '0)       guard <= guard - 1'b1;
        end
    end

    // Request sequencer: decodes requests, runs strobes and busy waits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= S_IDLE;
            pend        <= 1'b0;
            rd_mode     <= 1'b0;
            nand_cle    <= 1'b0;
            nand_ale    <= 1'b0;
            nand_io_out <= '0;
            nand_io_oe  <= 1'b0;
            col         <= '0;
            remain      <= '0;
            rd_valid    <= 1'b0;
            rd_data     <= '0;
            err_timeout <= 1'b0;
            bw_start    <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            bw_start <= 1'b0;
            if (go) pend <= 1'b0;
            unique case (st)
                S_IDLE: if (accept) begin
                    case (req_kind)
                        KIND_CMD, KIND_ADDR: begin
                            if (req_kind == KIND_CMD) col <= '0;
                            nand_cle    <= (req_kind == KIND_CMD);
                            nand_ale    <= (req_kind == KIND_ADDR);
                            nand_io_out <= req_data;
                            nand_io_oe  <= 1'b1;
                            rd_mode     <= 1'b0;
                            pend        <= 1'b1;
                            st          <= S_XFER;
                        end
                        KIND_WR: if (col < COL_END) begin
                            nand_io_out <= req_data;
                            nand_io_oe  <= 1'b1;
                            rd_mode     <= 1'b0;
                            col         <= col + 1'b1;
                            pend        <= 1'b1;
                            st          <= S_XFER;
                        end
                        KIND_RD: if ((req_len != '0) && (col < COL_END)) begin
                            nand_io_oe <= 1'b0;
                            rd_mode    <= 1'b1;
                            remain     <= req_len;
                            pend       <= 1'b1;
                            st         <= S_XFER;
                        end
                        KIND_WAIT: begin
                            bw_start <= 1'b1;
                            st       <= S_WAIT;
                        end
                        default: ;
                    endcase
                end
                S_XFER: begin
                    if (smp && rd_mode) begin
                        rd_valid <= 1'b1;
                        rd_data  <= nand_io_in;
                        col      <= col + 1'b1;
                        remain   <= remain - 1'b1;
                    end
                    if (dn) begin
                        if (rd_mode && (remain != '0) && (col < COL_END)) begin
                            pend <= 1'b1;
                        end else begin
                            st         <= S_IDLE;
                            rd_mode    <= 1'b0;
                            nand_cle   <= 1'b0;
                            nand_ale   <= 1'b0;
                            nand_io_oe <= 1'b0;
                        end
                    end
                end
                S_WAIT: begin
                    if (bw_ok) begin
                        st <= S_IDLE;
                    end else if (bw_exp) begin
                        err_timeout <= 1'b1;
                        st          <= S_IDLE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R11
    ce_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
    // R6
    oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_io_oe);
    // R3
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    // R10
    wp_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_we_n) |-> (guard == '0));
    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |=> err_timeout);
    // R7
    col_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col <= COL_END);
endmodule

// File: tb/nfc_seq_tb.sv
module nfc_seq_tb;
    localparam int T_LOW = 4, T_HIGH = 2, T_CYCLE = 7, WP_SETTLE = 13;
    localparam int TMO = 100, MASK = 13, PAGE = 2112;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, wp_enable = 1'b0, nand_rb_n = 1'b1;
    logic [2:0] req_kind = '0;
    logic [7:0] req_data = '0;
    logic [11:0] req_len = '0;
    logic req_ready, rd_valid, err_timeout, nand_ce_n, nand_cle, nand_ale;
    logic nand_we_n, nand_re_n, nand_wp_n, nand_io_oe;
    logic [7:0] rd_data, nand_io_out, nand_io_in;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int we_cnt = 0, re_rises = 0, rd_cnt = 0;
    int low_run = 0, since_rise = 1000, last_low = 0, wp_age = 1000, fall_wp_age = 0;
    logic prev_we = 1'b1, prev_re = 1'b1, prev_wp = 1'b0;
    logic [7:0] log_d [16];
    logic       log_c [16];
    logic       log_a [16];
    logic       log_o [16];

    always #4 clk = ~clk;

    assign nand_io_in = 8'(re_rises) ^ 8'h5A;

    nfc_seq #(.BUSY_TIMEOUT(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_data(req_data), .req_len(req_len),
        .rd_valid(rd_valid), .rd_data(rd_data), .wp_enable(wp_enable),
        .err_timeout(err_timeout), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_wp_n(nand_wp_n), .nand_rb_n(nand_rb_n), .nand_io_in(nand_io_in),
        .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Bus monitor sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            automatic logic any_low = !nand_we_n || !nand_re_n;
            if (nand_wp_n != prev_wp) wp_age = 0; else wp_age++;
            if (any_low && nand_ce_n) check(0, "R11", "ce high during strobe", 1, 0);
            if (!nand_re_n && nand_io_oe) check(0, "R6", "oe during read strobe", 1, 0);
            if (!nand_we_n && prev_we) begin
                fall_wp_age = wp_age;
                if (wp_age < WP_SETTLE) check(0, "R10", "wp settle gap", wp_age, WP_SETTLE);
            end
            if (any_low && (prev_we && prev_re)) begin
                if (since_rise < T_HIGH) check(0, "R5", "high time", since_rise, T_HIGH);
                if (since_rise + last_low < T_CYCLE)
                    check(0, "R5", "cycle time", since_rise + last_low, T_CYCLE);
                low_run = 0;
            end
            if (any_low) low_run++;
            if (!any_low && !(prev_we && prev_re)) begin
                check(low_run == T_LOW, "R5", "low width", low_run, T_LOW);
                last_low = low_run;
                since_rise = 0;
            end
            if (!any_low) since_rise++;
            if (nand_we_n && !prev_we) begin
                log_d[we_cnt % 16] = nand_io_out;
                log_c[we_cnt % 16] = nand_cle;
                log_a[we_cnt % 16] = nand_ale;
                log_o[we_cnt % 16] = nand_io_oe;
                we_cnt++;
            end
            if (nand_re_n && !prev_re) re_rises++;
            if (rd_valid) begin
                if (rd_data != (8'(rd_cnt) ^ 8'h5A))
                    check(0, "R6", "read byte", rd_data, 8'(rd_cnt) ^ 8'h5A);
                rd_cnt++;
            end
            prev_we = nand_we_n;
            prev_re = nand_re_n;
            prev_wp = nand_wp_n;
        end
    end

    task automatic send(input logic [2:0] k, input logic [7:0] d, input int n);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_kind = k; req_data = d; req_len = 12'(n); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle(output int c);
        c = 0;
        while (!req_ready) begin c++; @(negedge clk); end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(nand_ce_n && nand_we_n && nand_re_n, "R1", "strobes idle high", 0, 1);
        check(!nand_cle && !nand_ale && !nand_io_oe, "R1", "latches and oe low", 1, 0);
        check(nand_wp_n == 1'b0, "R1", "wp asserted", nand_wp_n, 0);
        check(!err_timeout && !rd_valid, "R1", "flags clear", 1, 0);
        check(req_ready == 1'b1, "R1", "ready", req_ready, 1);
    endtask

    task automatic t_wp_release();
        int c;
        wp_enable = 1'b1;
        send(3'd0, 8'hFF, 0);
        wait_idle(c);
        check(nand_wp_n == 1'b1, "R10", "wp follows enable", nand_wp_n, 1);
        check(fall_wp_age >= WP_SETTLE, "R10", "gap to first write strobe", fall_wp_age, WP_SETTLE);
    endtask

    task automatic t_write_seq();
        int c, base;
        logic [7:0] exp_d [6] = '{8'h80, 8'h00, 8'h07, 8'h12, 8'hA5, 8'h3C};
        logic [2:0] exp_k [6] = '{3'd0, 3'd1, 3'd1, 3'd1, 3'd2, 3'd2};
        base = we_cnt;
        for (int i = 0; i < 6; i++) begin
            send(exp_k[i], exp_d[i], 0);
            wait_idle(c);
        end
        check(we_cnt - base == 6, "R2", "write strobes for cmd/addr/data", we_cnt - base, 6);
        for (int i = 0; i < 6; i++) begin
            int j = (base + i) % 16;
            string rq = (exp_k[i] == 3'd0) ? "R2" : (exp_k[i] == 3'd1) ? "R3" : "R4";
            check(log_d[j] == exp_d[i], rq, "bus byte", log_d[j], exp_d[i]);
            check(log_c[j] == (exp_k[i] == 3'd0), rq, "cle", log_c[j], exp_k[i] == 3'd0);
            check(log_a[j] == (exp_k[i] == 3'd1), rq, "ale", log_a[j], exp_k[i] == 3'd1);
            check(log_o[j] == 1'b1, rq, "oe while writing", log_o[j], 1);
        end
    endtask

    task automatic t_read_short();
        int c, b_rd, b_re;
        send(3'd0, 8'h00, 0); wait_idle(c);
        b_rd = rd_cnt; b_re = re_rises;
        send(3'd3, 8'h00, 5); wait_idle(c);
        @(negedge clk);
        check(rd_cnt - b_rd == 5, "R6", "bytes returned", rd_cnt - b_rd, 5);
        check(re_rises - b_re == 5, "R6", "read strobes", re_rises - b_re, 5);
        check(nand_re_n && !nand_io_oe, "R6", "bus released after burst", 0, 1);
    endtask

    task automatic t_page_end();
        int c, b_rd, b_we;
        send(3'd0, 8'h30, 0); wait_idle(c);
        b_rd = rd_cnt;
        send(3'd3, 8'h00, PAGE + 8); wait_idle(c);
        @(negedge clk);
        check(rd_cnt - b_rd == PAGE, "R7", "burst clipped at page end", rd_cnt - b_rd, PAGE);
        b_we = we_cnt;
        send(3'd2, 8'h11, 0); wait_idle(c);
        repeat (12) @(negedge clk);
        check(we_cnt == b_we, "R7", "write past page end suppressed", we_cnt - b_we, 0);
        send(3'd0, 8'h85, 0); wait_idle(c);
        send(3'd2, 8'h77, 0); wait_idle(c);
        check(we_cnt - b_we == 2, "R2", "command restarts column", we_cnt - b_we, 2);
        check(log_d[(we_cnt - 1) % 16] == 8'h77, "R4", "byte after column reset",
              log_d[(we_cnt - 1) % 16], 8'h77);
    endtask

    task automatic t_wait_mask();
        int c;
        nand_rb_n = 1'b1;
        send(3'd4, 8'h00, 0); wait_idle(c);
        check(c >= MASK && c <= MASK + 6, "R8", "mask window length", c, MASK);
        check(err_timeout == 1'b0, "R8", "no error", err_timeout, 0);
    endtask

    task automatic t_wait_release();
        int c;
        nand_rb_n = 1'b0;
        send(3'd4, 8'h00, 0);
        repeat (40) @(negedge clk);
        check(req_ready == 1'b0, "R8", "still waiting while busy", req_ready, 0);
        nand_rb_n = 1'b1;
        wait_idle(c);
        check(c >= 2 && c <= 6, "R8", "cycles after release", c, 3);
        check(err_timeout == 1'b0, "R8", "no error on release", err_timeout, 0);
    endtask

    task automatic t_timeout();
        int c;
        nand_rb_n = 1'b0;
        send(3'd4, 8'h00, 0); wait_idle(c);
        check(c >= TMO - 1 && c <= TMO + 6, "R9", "timeout length", c, TMO);
        check(err_timeout == 1'b1, "R9", "error set", err_timeout, 1);
        nand_rb_n = 1'b1;
        send(3'd0, 8'h70, 0); wait_idle(c);
        repeat (5) @(negedge clk);
        check(err_timeout == 1'b1, "R9", "error sticky", err_timeout, 1);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_wp_release();
        t_write_seq();
        t_read_short();
        t_page_end();
        t_wait_mask();
        t_wait_release();
        t_timeout();
        check(n_chk > 12, "R5", "strobe timing observed", n_chk, 12);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule